// File: doc/BRIEF.md
# I/O Port Decoder at the Top of Memory

This block is the only peripheral on a 12-bit processor bus, and it answers at one address. The top address (0xFFF by default) is decoded. Any write to that address is routed by the high bits of the data word to one of three targets:

- a character display interface with a byte, a command/data select and an enable strobe;
- a pair of open-drain two-wire serial lines (clock and data);
- a request that carries a new field number to the memory extension logic.

A read from the same address returns one status word. That word holds the sensed levels of the two serial lines and five push buttons, which are active low and are not debounced.

The write path is a small state machine with three named states:

- **ST_IDLE**: no output pulse is active.
- **ST_LCD_STROBE**: for one cycle, raises the display enable with the byte and select that were captured.
- **ST_FIELD_REQ**: for one cycle, raises the field request with the captured field number.

From every state there are three transitions:

- **go_lcd**: an accepted display write leads to ST_LCD_STROBE.
- **go_field**: an accepted field write leads to ST_FIELD_REQ.
- **go_idle**: anything else, including serial-line writes, reserved writes and no write at all, leads to ST_IDLE.

Back-to-back writes therefore give back-to-back pulses. Writes to the serial lines change the line registers directly and leave the state machine in ST_IDLE. Reads are combinational.

Top module: `io_port`

## Requirements
- R1: Only a bus access whose address equals the I/O address is decoded. A write to any other address changes no output. A read from any other address, or a cycle with no read, returns 0 on `bus_rdata`.
- R2: A write whose data bits [11:9] are 000 is a display write. In the cycle after it, `lcd_byte` equals data bits [7:0], and `lcd_cmd` equals data bit 8 (1 = command, 0 = character data).
- R3: `lcd_strobe` is high for exactly the one cycle after each display write and low in every other cycle.
- R4: A write whose data bits [11:10] are 10 loads the serial-line registers: bit 9 is the clock line and bit 8 is the data line. From the next cycle, a stored 0 drives that line low (`*_pull_low`=1) and a stored 1 releases it (`*_pull_low`=0).
- R5: The serial-line outputs keep their value through every cycle that has no serial-line write.
- R6: A write whose data bits [11:10] are 11 is a field write. `field_req` is high for exactly the next cycle, and `field_val` then equals data bits [7:0] and holds that value until the next field write.
- R7: A write at the I/O address whose bit 11 is 0 and whose bits [10:9] are not 00 is reserved. It produces no strobe and no request, and it changes no display, serial-line or field output.
- R8: A read at the I/O address returns, in the same cycle, bits [11:10]=11, bit 9 = sensed clock line, bit 8 = sensed data line, bits [7:5]=111, and bits [4:0] = the button inputs as they are (0 = pressed, 1 = released).
- R9: While reset is asserted, and immediately after it, `lcd_strobe` and `field_req` are 0 and both serial lines are released. Reset takes effect asynchronously, even in the middle of a sequence.
- R10: `lcd_byte` and `lcd_cmd` hold their last written values between display writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Bus address |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 12 | Write data word |
| bus_rd | input | 1 | Read enable for the current cycle |
| bus_rdata | output | 12 | Read data word (0 unless a read hits the I/O address) |
| lcd_byte | output | 8 | Byte presented to the display |
| lcd_cmd | output | 1 | Display select: 1 command, 0 data |
| lcd_strobe | output | 1 | One-cycle display enable |
| scl_pull_low | output | 1 | Serial clock open-drain enable (1 = drive low) |
| sda_pull_low | output | 1 | Serial data open-drain enable (1 = drive low) |
| scl_sense | input | 1 | Sensed level of the serial clock line |
| sda_sense | input | 1 | Sensed level of the serial data line |
| btn_n | input | 5 | Push buttons, 0 when pressed |
| field_req | output | 1 | One-cycle field-set request |
| field_val | output | 8 | Field number carried with the request |

## Verification
The write decoder is driven with data words chosen so that each top-bit pattern is present: 000 with the select bit both clear and set, 10 with all four clock/data combinations, 11, and the two reserved patterns 001 and 011. Each result shows whether the word went to exactly one target. The same kinds of words are also sent to addresses next to the I/O address, to tell the address compare apart from the data-bit decode. Writes follow each other in consecutive cycles, so a strobe that lasts too long, or outputs that are not held, show up against the next vector. Reads use opposite line levels and button patterns, so that a swapped or inverted bit becomes visible.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

    localparam int WORD_W = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LCD_STROBE,
        ST_FIELD_REQ
    } io_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_LCD,
        WK_I2C,
        WK_FIELD
    } wr_kind_e;

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
    import io_port_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] IO_ADDR = '1
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              hit,
    output wr_kind_e          kind
);

    always_comb begin
        hit  = (addr == IO_ADDR);
        kind = WK_NONE;
        if (wr && hit) begin
            unique case (wdata[WORD_W-1 -: 2])
                2'b00:   kind = wdata[WORD_W-3] ? WK_NONE : WK_LCD;
                2'b01:   kind = WK_NONE;
                2'b10:   kind = WK_I2C;
                2'b11:   kind = WK_FIELD;
                default: kind = WK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/io_port_lines.sv
module io_port_lines #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [NLINES-1:0] level,
    output logic [NLINES-1:0] pull_low
);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic line_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q <= 1'b1;
            end else if (upd) begin
                line_q <= level[g];
            end
        end

        assign pull_low[g] = ~line_q;
    end

endmodule

// File: rtl/io_port_rdmux.sv
module io_port_rdmux
    import io_port_pkg::*;
#(
    parameter int BTN_N = 5
) (
    input  logic              sel,
    input  logic              scl_sense,
    input  logic              sda_sense,
    input  logic [BTN_N-1:0]  btn_n,
    output logic [WORD_W-1:0] rdata
);

    localparam int PAD_W = WORD_W - 4 - BTN_N;

    always_comb begin
        if (sel) begin
            rdata = {2'b11, scl_sense, sda_sense, {PAD_W{1'b1}}, btn_n};
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/io_port.sv
module io_port
    import io_port_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] IO_ADDR = 12'hFFF,
    parameter int                BTN_N   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] lcd_byte,
    output logic              lcd_cmd,
    output logic              lcd_strobe,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic              scl_sense,
    input  logic              sda_sense,
    input  logic [BTN_N-1:0]  btn_n,
    output logic              field_req,
    output logic [BYTE_W-1:0] field_val
);

    localparam int SEL_BIT = BYTE_W;
    localparam int SCL_BIT = BYTE_W + 1;

    logic      hit;
    wr_kind_e  kind;
    io_state_e state_q, state_d;
    logic [1:0] pull_low;

    io_port_decode #(
        .ADDR_W (ADDR_W),
        .IO_ADDR(IO_ADDR)
    ) u_decode (
        .wr   (bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .hit  (hit),
        .kind (kind)
    );

    // Next state: go_lcd, go_field, or go_idle from any state.
    always_comb begin
        unique case (kind)
            WK_LCD:   state_d = ST_LCD_STROBE;
            WK_FIELD: state_d = ST_FIELD_REQ;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload registers captured alongside the transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcd_byte  <= '0;
            lcd_cmd   <= 1'b0;
            field_val <= '0;
        end else begin
            if (kind == WK_LCD) begin
                lcd_byte <= bus_wdata[BYTE_W-1:0];
                lcd_cmd  <= bus_wdata[SEL_BIT];
            end
            if (kind == WK_FIELD) begin
                field_val <= bus_wdata[BYTE_W-1:0];
            end
        end
    end

    // Pulse outputs decoded from the state.
    always_comb begin
        lcd_strobe = 1'b0;
        field_req  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_LCD_STROBE: lcd_strobe = 1'b1;
            ST_FIELD_REQ:  field_req  = 1'b1;
            default:       ;
        endcase
    end

    io_port_lines #(
        .NLINES(2)
    ) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (kind == WK_I2C),
        .level   (bus_wdata[SCL_BIT:SEL_BIT]),
        .pull_low(pull_low)
    );

    assign scl_pull_low = pull_low[1];
    assign sda_pull_low = pull_low[0];

    io_port_rdmux #(
        .BTN_N(BTN_N)
    ) u_rdmux (
        .sel      (bus_rd && hit),
        .scl_sense(scl_sense),
        .sda_sense(sda_sense),
        .btn_n    (btn_n),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/io_port_chk.sv
module io_port_chk
    import io_port_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] IO_ADDR = 12'hFFF,
    parameter int                BTN_N   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [BYTE_W-1:0] lcd_byte,
    input logic              lcd_cmd,
    input logic              lcd_strobe,
    input logic              scl_pull_low,
    input logic              sda_pull_low,
    input logic              scl_sense,
    input logic              sda_sense,
    input logic [BTN_N-1:0]  btn_n,
    input logic              field_req,
    input logic [BYTE_W-1:0] field_val
);

    logic at_io, w_lcd, w_i2c, w_fld;
    assign at_io = (bus_addr == IO_ADDR);
    assign w_lcd = bus_wr && at_io && (bus_wdata[11:9] == 3'b000);
    assign w_i2c = bus_wr && at_io && (bus_wdata[11:10] == 2'b10);
    assign w_fld = bus_wr && at_io && (bus_wdata[11:10] == 2'b11);

    // R2
    lcd_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_lcd |=> (lcd_byte == $past(bus_wdata[7:0])) && (lcd_cmd == $past(bus_wdata[8])));

    // R3
    lcd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_lcd |=> lcd_strobe);

    // R3
    lcd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_lcd |=> !lcd_strobe);

    // R10
    lcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_lcd |=> $stable(lcd_byte) && $stable(lcd_cmd));

    // R4
    line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_i2c |=> (scl_pull_low == !$past(bus_wdata[9])) && (sda_pull_low == !$past(bus_wdata[8])));

    // R5
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_i2c |=> $stable(scl_pull_low) && $stable(sda_pull_low));

    // R6
    field_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_fld |=> field_req && (field_val == $past(bus_wdata[7:0])));

    // R6
    field_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_fld |=> !field_req && $stable(field_val));

    // R8
    read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_io) |-> (bus_rdata[11:10] == 2'b11) && (bus_rdata[7:5] == 3'b111)
            && (bus_rdata[9] == scl_sense) && (bus_rdata[8] == sda_sense)
            && (bus_rdata[4:0] == btn_n));

    // R1
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && at_io) |-> (bus_rdata == '0));

endmodule

bind io_port io_port_chk #(
    .ADDR_W (ADDR_W),
    .IO_ADDR(IO_ADDR),
    .BTN_N  (BTN_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .lcd_byte    (lcd_byte),
    .lcd_cmd     (lcd_cmd),
    .lcd_strobe  (lcd_strobe),
    .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low),
    .scl_sense   (scl_sense),
    .sda_sense   (sda_sense),
    .btn_n       (btn_n),
    .field_req   (field_req),
    .field_val   (field_val)
);

// File: tb/tb_io_port.sv
module tb_io_port;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    // {addr[12], wdata[12], strobe, cmd, byte[8], freq, fval[8], scl_low, sda_low}
    localparam logic [44:0] VEC [NVEC] = '{
        {12'hFFF, 12'h041, 1'b1, 1'b0, 8'h41, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 data byte
        {12'hFFF, 12'h138, 1'b1, 1'b1, 8'h38, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 command byte
        {12'hFFF, 12'h800, 1'b0, 1'b1, 8'h38, 1'b0, 8'h00, 1'b1, 1'b1}, // R4 both low
        {12'hFFF, 12'hA00, 1'b0, 1'b1, 8'h38, 1'b0, 8'h00, 1'b0, 1'b1}, // R4 clock released
        {12'hFFF, 12'h900, 1'b0, 1'b1, 8'h38, 1'b0, 8'h00, 1'b1, 1'b0}, // R4 data released
        {12'hFFF, 12'hC05, 1'b0, 1'b1, 8'h38, 1'b1, 8'h05, 1'b1, 1'b0}, // R6 field, R5 hold
        {12'hFFF, 12'h2FF, 1'b0, 1'b1, 8'h38, 1'b0, 8'h05, 1'b1, 1'b0}, // R7 reserved 001
        {12'hFFE, 12'h055, 1'b0, 1'b1, 8'h38, 1'b0, 8'h05, 1'b1, 1'b0}, // R1 other address
        {12'hFFF, 12'h0FF, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h05, 1'b1, 1'b0}, // R2 all-ones byte
        {12'hFFF, 12'hB00, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h05, 1'b0, 1'b0}, // R4 both released
        {12'hFFF, 12'hFFF, 1'b0, 1'b0, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0}, // R6 field all ones
        {12'h7FF, 12'h800, 1'b0, 1'b0, 8'hFF, 1'b0, 8'hFF, 1'b0, 1'b0}, // R1 line write elsewhere
        {12'hFFF, 12'h600, 1'b0, 1'b0, 8'hFF, 1'b0, 8'hFF, 1'b0, 1'b0}  // R7 reserved 011
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_rdata;
    logic [7:0]  lcd_byte;
    logic        lcd_cmd;
    logic        lcd_strobe;
    logic        scl_pull_low;
    logic        sda_pull_low;
    logic        scl_sense = 1'b1;
    logic        sda_sense = 1'b1;
    logic [4:0]  btn_n = 5'b11111;
    logic        field_req;
    logic [7:0]  field_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    io_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .lcd_byte    (lcd_byte),
        .lcd_cmd     (lcd_cmd),
        .lcd_strobe  (lcd_strobe),
        .scl_pull_low(scl_pull_low),
        .sda_pull_low(sda_pull_low),
        .scl_sense   (scl_sense),
        .sda_sense   (sda_sense),
        .btn_n       (btn_n),
        .field_req   (field_req),
        .field_val   (field_val)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R9: outputs under reset
        repeat (3) @(negedge clk);
        check("R9", "strobe in reset", int'(lcd_strobe), 0);
        check("R9", "field_req in reset", int'(field_req), 0);
        check("R9", "scl released", int'(scl_pull_low), 0);
        check("R9", "sda released", int'(sda_pull_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "strobe after reset", int'(lcd_strobe), 0);
        check("R1", "idle rdata", int'(bus_rdata), 0);

        // Vector walk: writes in consecutive cycles
        for (int i = 0; i < NVEC; i++) begin
            bus_wr    = 1'b1;
            bus_addr  = VEC[i][44:33];
            bus_wdata = VEC[i][32:21];
            @(negedge clk);
            check("R3", $sformatf("v%0d strobe", i), int'(lcd_strobe), int'(VEC[i][20]));
            check("R2", $sformatf("v%0d cmd", i), int'(lcd_cmd), int'(VEC[i][19]));
            check("R2", $sformatf("v%0d byte", i), int'(lcd_byte), int'(VEC[i][18:11]));
            check("R6", $sformatf("v%0d field_req", i), int'(field_req), int'(VEC[i][10]));
            check("R6", $sformatf("v%0d field_val", i), int'(field_val), int'(VEC[i][9:2]));
            check("R4", $sformatf("v%0d scl", i), int'(scl_pull_low), int'(VEC[i][1]));
            check("R4", $sformatf("v%0d sda", i), int'(sda_pull_low), int'(VEC[i][0]));
        end
        bus_wr = 1'b0;
        @(negedge clk);
        check("R3", "strobe after idle", int'(lcd_strobe), 0);
        check("R6", "req after idle", int'(field_req), 0);

        // R3 / R10: single display write then idle
        bus_wr = 1'b1; bus_addr = 12'hFFF; bus_wdata = 12'h1A5;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R3", "single strobe", int'(lcd_strobe), 1);
        check("R2", "single byte", int'(lcd_byte), 8'hA5);
        @(negedge clk);
        check("R3", "strobe ends", int'(lcd_strobe), 0);
        check("R10", "byte held", int'(lcd_byte), 8'hA5);
        check("R10", "cmd held", int'(lcd_cmd), 1);

        // R8: read word patterns
        bus_rd = 1'b1; bus_addr = 12'hFFF;
        scl_sense = 1'b0; sda_sense = 1'b1; btn_n = 5'b10110;
        #1;
        check("R8", "read low clock", int'(bus_rdata), 12'hDF6);
        scl_sense = 1'b1; sda_sense = 1'b0; btn_n = 5'b00000;
        #1;
        check("R8", "read all pressed", int'(bus_rdata), 12'hEE0);
        bus_addr = 12'hFFD;
        #1;
        check("R1", "read other address", int'(bus_rdata), 0);
        bus_rd = 1'b0; bus_addr = 12'hFFF;
        #1;
        check("R1", "no read", int'(bus_rdata), 0);

        // R9: reset in the middle of a sequence
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = 12'h800;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4", "lines pulled", int'(scl_pull_low & sda_pull_low), 1);
        rst_n = 1'b0;
        #1;
        check("R9", "scl released by reset", int'(scl_pull_low), 0);
        check("R9", "sda released by reset", int'(sda_pull_low), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "scl stays released", int'(scl_pull_low), 0);
        report();
    end

endmodule